// File: doc/BRIEF.md
# Daylight-Saving Hour Adjuster

This block runs beside a 24-hour BCD time-of-day counter. Software can ask it to move the clock forward by one hour or back by one hour. The counter is never stopped. A request is held as pending. At the next one-second tick the block works out the corrected hour from the counter's current hour value. It then presents that value on `hour_out` and pulses `hour_wr` for one cycle, so the counter can load it. The counter's seconds and minutes keep their normal increment on that same tick; this block never touches them.

If a forward request and a backward request are both pending at the same tick, they cancel. Moving forward from hour 23 gives 00, and the date does not advance. Moving back from hour 00 is dropped. In every case the pending requests are cleared by the tick that consumes them.

A separate memo bit records whether a daylight-saving change has been made. Only software writes it, through `memo_wr`/`memo_din`. The adjustment logic never changes it.

Top module: `dst_hour_adj`

## Requirements
- R1: After reset, `hour_out` is 8'h00, `hour_wr` is 0, `pending` is 0 and `memo` is 0.
- R2: A one-cycle `add_req` makes `pending` read 1 from the next cycle. At the next `sec_tick`, `hour_wr` is 1 in the cycle after the tick, and `hour_out` equals the BCD hour sampled with that tick plus one.
- R3: A one-cycle `sub_req` that is applied at a tick gives `hour_out` equal to the sampled BCD hour minus one, with `hour_wr` pulsed in the cycle after the tick.
- R4: No adjustment takes effect without a tick. While a request is pending and `sec_tick` stays low, `hour_wr` stays 0 and `hour_out` holds its value.
- R5: The tick that consumes the requests clears `pending` in the following cycle, unless a new request arrives in the tick cycle itself.
- R6: If both directions are pending at the same tick, there is no `hour_wr` pulse, `hour_out` is unchanged and `pending` clears.
- R7: Adding at hour 8'h23 gives 8'h00, with a `hour_wr` pulse.
- R8: Subtracting at hour 8'h00 is ignored: there is no `hour_wr` pulse, `hour_out` is unchanged and the request is cleared.
- R9: `memo` takes `memo_din` in the cycle after `memo_wr` is high, and otherwise never changes, including across adjustments.
- R10: Whenever `hour_wr` is 1, `hour_out` is valid BCD: upper digit 0 to 2, lower digit 0 to 9, value 00 to 23.
- R11: A request raised in the same cycle as `sec_tick` is not applied by that tick. It stays pending for the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| add_req | input | 1 | One-cycle strobe: add one hour |
| sub_req | input | 1 | One-cycle strobe: subtract one hour |
| memo_wr | input | 1 | Write enable for the memo bit |
| memo_din | input | 1 | Value written to the memo bit |
| sec_tick | input | 1 | One-second boundary pulse from the calendar |
| hour_in | input | 8 | Current hour of the running counter, two BCD digits |
| hour_out | output | 8 | Corrected hour, two BCD digits |
| hour_wr | output | 1 | One-cycle load strobe for `hour_out` |
| pending | output | 1 | A request is waiting for the next tick |
| memo | output | 1 | Software daylight-saving memo bit |

## Verification
The following are checked on every cycle:
- a load strobe only follows a tick that had a request pending;
- requests always register as pending, and a consumed request clears;
- a request raised in a tick cycle never loads on that tick;
- the loaded hour is valid BCD;
- the memo bit moves only on its own write.

Only the bench scenarios can show the arithmetic itself, which is checked against a scoreboard of expected hours:
- the BCD carries and borrows, such as 19 to 20 and 10 to 09;
- the 23-to-00 wrap;
- dropping a subtract at 00;
- cancellation when both directions are pending;
- that the memo survives adjustments.

// File: rtl/dst_adj_pkg.sv
package dst_adj_pkg;
   typedef logic [7:0] bcd_hour_t;

   localparam int unsigned DIR_ADD = 0;
   localparam int unsigned DIR_SUB = 1;
   localparam int unsigned NUM_DIR = 2;

   function automatic int unsigned bcd_to_bin(input bcd_hour_t h);
      int unsigned tens;
      int unsigned ones;
      tens = {28'd0, h[7:4]};
      ones = {28'd0, h[3:0]};
      return tens * 10 + ones;
   endfunction

   function automatic bcd_hour_t bin_to_bcd(input int unsigned v);
      int unsigned tens;
      int unsigned ones;
      tens = v / 10;
      ones = v % 10;
      return {tens[3:0], ones[3:0]};
   endfunction
endpackage

// File: rtl/dst_req_latch.sv
module dst_req_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic tick_i,
   output logic pend_o
);
   // A strobe arriving in the tick cycle survives into the next period.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_o <= 1'b0;
      else if (set_i)
         pend_o <= 1'b1;
      else if (tick_i)
         pend_o <= 1'b0;
   end
endmodule

// File: rtl/dst_hour_math.sv
module dst_hour_math
   import dst_adj_pkg::*;
#(
   parameter int unsigned DAY_HOURS = 24,
   parameter bit          WRAP_ADD  = 1'b1
) (
   input  bcd_hour_t hour_i,
   input  logic      inc_i,
   input  logic      dec_i,
   output bcd_hour_t hour_o,
   output logic      load_o
);
   localparam int unsigned LAST_HOUR = DAY_HOURS - 1;

   logic top_ok;
   int unsigned cur;

   generate
      if (WRAP_ADD) begin : g_wrap
         assign top_ok = 1'b1;
      end else begin : g_sat
         assign top_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      cur    = bcd_to_bin(hour_i);
      hour_o = hour_i;
      load_o = 1'b0;
      if (inc_i && !dec_i) begin
         if (cur >= LAST_HOUR) begin
            hour_o = '0;
            load_o = top_ok;
         end else begin
            hour_o = bin_to_bcd(cur + 1);
            load_o = 1'b1;
         end
      end else if (dec_i && !inc_i) begin
         if (cur != 0 && cur <= LAST_HOUR) begin
            hour_o = bin_to_bcd(cur - 1);
            load_o = 1'b1;
         end
      end
   end
endmodule

// File: rtl/dst_memo.sv
module dst_memo (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_i,
   input  logic d_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q_o <= 1'b0;
      else if (wr_i)
         q_o <= d_i;
   end
endmodule

// File: rtl/dst_hour_adj.sv
module dst_hour_adj
   import dst_adj_pkg::*;
#(
   parameter int unsigned DAY_HOURS = 24,
   parameter bit          WRAP_ADD  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       add_req,
   input  logic       sub_req,
   input  logic       memo_wr,
   input  logic       memo_din,
   input  logic       sec_tick,
   input  logic [7:0] hour_in,
   output logic [7:0] hour_out,
   output logic       hour_wr,
   output logic       pending,
   output logic       memo
);
   generate
      if (DAY_HOURS < 2 || DAY_HOURS > 100) begin : g_bad_hours
         $error("DAY_HOURS must lie in 2..100");
      end
   endgenerate

   logic [NUM_DIR-1:0] req_vec;
   logic [NUM_DIR-1:0] pend_vec;
   bcd_hour_t          adj_hour;
   logic               adj_load;
   bcd_hour_t          hour_q;
   logic               wr_q;

   assign req_vec[DIR_ADD] = add_req;
   assign req_vec[DIR_SUB] = sub_req;

   generate
      for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
         dst_req_latch u_latch (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (req_vec[d]),
            .tick_i (sec_tick),
            .pend_o (pend_vec[d])
         );
      end
   endgenerate

   dst_hour_math #(
      .DAY_HOURS (DAY_HOURS),
      .WRAP_ADD  (WRAP_ADD)
   ) u_math (
      .hour_i (hour_in),
      .inc_i  (pend_vec[DIR_ADD]),
      .dec_i  (pend_vec[DIR_SUB]),
      .hour_o (adj_hour),
      .load_o (adj_load)
   );

   dst_memo u_memo (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_i  (memo_wr),
      .d_i   (memo_din),
      .q_o   (memo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hour_q <= '0;
         wr_q   <= 1'b0;
      end else begin
         wr_q <= sec_tick & adj_load;
         if (sec_tick && adj_load)
            hour_q <= adj_hour;
      end
   end

   assign hour_out = hour_q;
   assign hour_wr  = wr_q;
   assign pending  = |pend_vec;
endmodule

// File: rtl/dst_hour_adj_chk.sv
module dst_hour_adj_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       add_req,
   input logic       sub_req,
   input logic       memo_wr,
   input logic       memo_din,
   input logic       sec_tick,
   input logic [7:0] hour_in,
   input logic [7:0] hour_out,
   input logic       hour_wr,
   input logic       pending,
   input logic       memo
);
   AST_WR_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      hour_wr |-> $past(sec_tick)); // R4
   AST_WR_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      hour_wr |-> $past(pending)); // R2
   AST_REQ_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (add_req || sub_req) |=> pending); // R2
   AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !add_req && !sub_req) |=> !pending); // R5
   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_tick |=> ($stable(hour_out) && !hour_wr)); // R4
   AST_TICK_REQ_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !pending) |=> !hour_wr); // R11
   AST_HOUR_BCD: assert property (@(posedge clk) disable iff (!rst_n)
      hour_wr |-> (hour_out[3:0] <= 4'd9 && hour_out <= 8'h23)); // R10
   AST_MEMO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !memo_wr |=> $stable(memo)); // R9
   AST_MEMO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      memo_wr |=> (memo == $past(memo_din))); // R9
endmodule

bind dst_hour_adj dst_hour_adj_chk u_chk (.*);

// File: tb/dst_hour_adj_bench.sv
module dst_hour_adj_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       add_req = 1'b0;
   logic       sub_req = 1'b0;
   logic       memo_wr = 1'b0;
   logic       memo_din = 1'b0;
   logic       sec_tick = 1'b0;
   logic [7:0] hour_in = 8'h00;
   logic [7:0] hour_out;
   logic       hour_wr;
   logic       pending;
   logic       memo;

   int         n_chk = 0;
   int         n_fail = 0;
   bit         done = 1'b0;
   logic [7:0] exp_q[$];

   always #2 clk = ~clk;

   dst_hour_adj u_dst_hour_adj (
      .clk(clk), .rst_n(rst_n), .add_req(add_req), .sub_req(sub_req),
      .memo_wr(memo_wr), .memo_din(memo_din), .sec_tick(sec_tick),
      .hour_in(hour_in), .hour_out(hour_out), .hour_wr(hour_wr),
      .pending(pending), .memo(memo)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever a load strobe appears
   always @(negedge clk) begin
      if (rst_n && hour_wr) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected load", int'(hour_out), 0);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(hour_out == e, "R2/R3/R7 loaded hour", int'(hour_out), int'(e));
            chk(hour_out[3:0] <= 4'd9 && hour_out <= 8'h23, "R10 bcd range",
                int'(hour_out), 8'h23);
         end
      end
   end

   task automatic request(input bit a, input bit s);
      @(negedge clk);
      add_req = a;
      sub_req = s;
      @(negedge clk);
      add_req = 1'b0;
      sub_req = 1'b0;
   endtask

   task automatic tick(input logic [7:0] h, input bit load, input logic [7:0] e, input string req);
      @(negedge clk);
      hour_in  = h;
      sec_tick = 1'b1;
      if (load) exp_q.push_back(e);
      @(negedge clk);
      sec_tick = 1'b0;
      chk(hour_wr == load, req, int'(hour_wr), int'(load));
      chk(pending == 1'b0, "R5 pending cleared", int'(pending), 0);
   endtask

   function automatic logic [7:0] to_bcd(input int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(hour_out == 8'h00, "R1 hour_out", int'(hour_out), 0);
      chk(hour_wr == 1'b0, "R1 hour_wr", int'(hour_wr), 0);
      chk(pending == 1'b0, "R1 pending", int'(pending), 0);
      chk(memo == 1'b0, "R1 memo", int'(memo), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 add, R4 no effect before tick
      request(1'b1, 1'b0);
      chk(pending == 1'b1, "R2 pending set", int'(pending), 1);
      repeat (5) begin
         @(negedge clk);
         chk(hour_wr == 1'b0 && hour_out == 8'h00, "R4 held without tick", int'(hour_out), 0);
      end
      tick(8'h07, 1'b1, 8'h08, "R2 add strobe");

      // R3 subtract with borrow
      request(1'b0, 1'b1);
      tick(8'h10, 1'b1, 8'h09, "R3 sub strobe");

      // R2 carry 19 -> 20
      request(1'b1, 1'b0);
      tick(8'h19, 1'b1, 8'h20, "R2 carry strobe");

      // R7 wrap
      request(1'b1, 1'b0);
      tick(8'h23, 1'b1, 8'h00, "R7 wrap strobe");

      request(1'b1, 1'b0);
      tick(8'h12, 1'b1, 8'h13, "R2 add strobe");

      // R8 sub at zero ignored
      request(1'b0, 1'b1);
      tick(8'h00, 1'b0, 8'h00, "R8 no load");
      chk(hour_out == 8'h13, "R8 hour unchanged", int'(hour_out), 8'h13);

      // R6 both cancel
      request(1'b1, 1'b1);
      chk(pending == 1'b1, "R6 pending", int'(pending), 1);
      tick(8'h15, 1'b0, 8'h00, "R6 no load");
      chk(hour_out == 8'h13, "R6 hour unchanged", int'(hour_out), 8'h13);

      // R11 request in tick cycle waits
      @(negedge clk);
      hour_in  = 8'h05;
      add_req  = 1'b1;
      sec_tick = 1'b1;
      @(negedge clk);
      add_req  = 1'b0;
      sec_tick = 1'b0;
      chk(hour_wr == 1'b0, "R11 no load on same tick", int'(hour_wr), 0);
      chk(pending == 1'b1, "R11 still pending", int'(pending), 1);
      tick(8'h05, 1'b1, 8'h06, "R11 applied next tick");

      // R9 memo
      @(negedge clk);
      memo_wr = 1'b1;
      memo_din = 1'b1;
      @(negedge clk);
      memo_wr = 1'b0;
      memo_din = 1'b0;
      chk(memo == 1'b1, "R9 memo written", int'(memo), 1);
      request(1'b0, 1'b1);
      tick(8'h08, 1'b1, 8'h07, "R3 sub strobe");
      chk(memo == 1'b1, "R9 memo kept across adjust", int'(memo), 1);
      @(negedge clk);
      memo_wr = 1'b1;
      @(negedge clk);
      memo_wr = 1'b0;
      chk(memo == 1'b0, "R9 memo cleared", int'(memo), 0);

      // R10 sweep of every hour both ways
      for (int h = 0; h < 24; h++) begin
         request(1'b1, 1'b0);
         tick(to_bcd(h), 1'b1, to_bcd((h + 1) % 24), "R10 add sweep");
      end
      for (int h = 1; h < 24; h++) begin
         request(1'b0, 1'b1);
         tick(to_bcd(h), 1'b1, to_bcd(h - 1), "R10 sub sweep");
      end

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
      finish_run();
   end
endmodule